// File: doc/BRIEF.md
# Base-Limit Address Guard

This block stands between a processor core and its memory bus and screens each address the core sends. Two configuration registers describe one contiguous window of physical memory: a start address and a window size. While the core runs in user mode, a request whose address falls outside that window never reaches the bus. A one-cycle trap pulse then reports the faulting address and a cause code. While the core runs in kernel mode, every request goes through untouched.

The two window registers can be loaded only while the core is in kernel mode. A load attempted from user mode is dropped, and it raises its own trap cause. The window test is done one bit wider than the address, so a window whose end passes the top of the address space never wraps back to low addresses. Both registers clear to zero at reset, which makes the window empty. Kernel boot code therefore runs without limits, and any user access traps until the window has been set up.

Top module: `bl_guard`

## Requirements
- R1: After reset `trap_valid` is 0, `trap_cause` is 0, and start and size both read as zero in behaviour: every user-mode request is blocked until the registers are loaded.
- R2: A user-mode address A is legal exactly when start <= A <= start + size - 1, both ends inclusive. With start 300040 and size 120900, addresses 300040 and 420939 pass, while 300039 and 420940 are blocked.
- R3: The window test never wraps. With start 2^32-16 and size 32, address 2^32-1 passes and address 0..15 is blocked.
- R4: A user-mode request to an illegal address drives `mem_req` low in the same cycle. In the next cycle `trap_valid` is 1, `trap_cause` is 2'b01 (range fault) and `trap_addr` holds the faulting address.
- R5: A user-mode request to a legal address drives `mem_req` high in the same cycle, with `mem_addr` and `mem_we` equal to `cpu_addr` and `cpu_we`. It raises no trap.
- R6: In kernel mode (`cpu_kmode` = 1) every request reaches memory and raises no trap, whatever its address.
- R7: A configuration write in kernel mode loads the start register when `cfg_sel` = 0 and the size register when `cfg_sel` = 1. The new value governs requests from the next cycle on.
- R8: A configuration write in user mode changes neither register. In the next cycle it raises a trap with `trap_cause` 2'b10 (privilege fault).
- R9: When a user-mode configuration write and a user-mode request share one cycle, the trap carries cause 2'b10. `trap_addr` holds `cpu_addr` of that cycle. The request itself is still passed or blocked by the window test alone.
- R10: `trap_valid` is high in exactly the cycles that follow a faulting cycle, one cycle per faulting cycle, and low otherwise with `trap_cause` 2'b00.
- R11: A size of zero makes every user-mode address illegal, including the start address itself.
- R12: The window test ignores `cpu_we`: fetches and loads (`cpu_we` = 0) are checked in exactly the same way as stores (`cpu_we` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Core request valid |
| cpu_addr | input | ADDR_W | Physical address of the request |
| cpu_we | input | 1 | 1 = store, 0 = fetch or load |
| cpu_kmode | input | 1 | 1 = kernel mode, 0 = user mode |
| cfg_wr | input | 1 | Privileged register write strobe |
| cfg_sel | input | 1 | 0 = start register, 1 = size register |
| cfg_data | input | ADDR_W | Value to load |
| mem_req | output | 1 | Request forwarded to the memory bus |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_we | output | 1 | Forwarded write flag |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_addr | output | ADDR_W | Address presented in the faulting cycle |
| trap_cause | output | 2 | 01 range fault, 10 privilege fault, 00 none |

## Verification
A user-mode register write and a user-mode request can land in the same cycle, so the privilege fault and the range test meet at one trap output. The bench drives both strobes together, once with an illegal address and once with a legal one. It then checks that the bus gating follows the window test alone while the reported cause is the privilege fault. A behavioural model built on 64-bit integers predicts the gating in every cycle and the trap one cycle later. Random traffic clustered around the window edges runs after the directed cases.

// File: rtl/bl_guard_pkg.sv
package bl_guard_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'b00,
      CAUSE_RANGE = 2'b01,
      CAUSE_PRIV  = 2'b10
   } trap_cause_e;

   localparam logic SEL_START = 1'b0;
   localparam logic SEL_SIZE  = 1'b1;

endpackage

// File: rtl/bl_window_regs.sv
module bl_window_regs
   import bl_guard_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              kmode,
   output logic [ADDR_W-1:0] start_o,
   output logic [ADDR_W-1:0] size_o,
   output logic              priv_fault_o
);

   logic [ADDR_W-1:0] start_q;
   logic [ADDR_W-1:0] size_q;
   logic              wr_ok;

   assign wr_ok        = wr_req & kmode;
   assign priv_fault_o = wr_req & ~kmode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         size_q  <= '0;
      end else if (wr_ok) begin
         if (wr_sel == SEL_START) start_q <= wr_data;
         else                     size_q  <= wr_data;
      end
   end

   assign start_o = start_q;
   assign size_o  = size_q;

   // R8: without a kernel write, both registers hold
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_req && kmode) |=> ($stable(start_q) && $stable(size_q)));

   // R7: a kernel write lands in the selected register only
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && kmode && wr_sel == SEL_START) |=> (start_q == $past(wr_data) && $stable(size_q)));

endmodule

// File: rtl/bl_range_cmp.sv
module bl_range_cmp #(
   parameter int ADDR_W   = 32,
   parameter bit SUB_FORM = 1'b0
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic [ADDR_W-1:0] size_i,
   output logic              legal_o
);

   localparam int EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] a_x;
   logic [EXT_W-1:0] s_x;
   logic [EXT_W-1:0] n_x;
   logic             above_start;

   assign a_x         = {1'b0, addr_i};
   assign s_x         = {1'b0, start_i};
   assign n_x         = {1'b0, size_i};
   assign above_start = (a_x >= s_x);

   generate
      if (SUB_FORM) begin : g_offset
         logic [EXT_W-1:0] off_x;
         assign off_x   = a_x - s_x;
         assign legal_o = above_start && (off_x < n_x);
      end else begin : g_endpoint
         logic [EXT_W-1:0] end_x;
         assign end_x   = s_x + n_x;
         assign legal_o = above_start && (a_x < end_x);
      end
   endgenerate

   always_comb begin
      if (legal_o) begin
         p_lower_r2: assert (addr_i >= start_i);
         p_nonempty_r11: assert (size_i != '0);
      end
   end

endmodule

// File: rtl/bl_fault_gate.sv
module bl_fault_gate
   import bl_guard_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic              kmode_i,
   input  logic              legal_i,
   input  logic              priv_fault_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_we_o,
   output logic              trap_valid_o,
   output logic [ADDR_W-1:0] trap_addr_o,
   output trap_cause_e       trap_cause_o
);

   logic              range_fault;
   logic              any_fault;
   trap_cause_e       cause_d;
   logic              trap_q;
   logic [ADDR_W-1:0] taddr_q;
   trap_cause_e       cause_q;

   assign range_fault = req_i & ~kmode_i & ~legal_i;
   assign any_fault   = range_fault | priv_fault_i;

   always_comb begin
      if (priv_fault_i)     cause_d = CAUSE_PRIV;
      else if (range_fault) cause_d = CAUSE_RANGE;
      else                  cause_d = CAUSE_NONE;
   end

   assign mem_req_o  = req_i & ~range_fault;
   assign mem_addr_o = addr_i;
   assign mem_we_o   = we_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_q  <= 1'b0;
         taddr_q <= '0;
         cause_q <= CAUSE_NONE;
      end else begin
         trap_q  <= any_fault;
         taddr_q <= any_fault ? addr_i : '0;
         cause_q <= cause_d;
      end
   end

   assign trap_valid_o = trap_q;
   assign trap_addr_o  = taddr_q;
   assign trap_cause_o = cause_q;

   // R4: illegal user request never reaches the bus
   p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !kmode_i && !legal_i) |-> !mem_req_o);

   // R6: kernel requests always pass
   p_kernel_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && kmode_i) |-> mem_req_o);

   // R10: a trap follows only a faulting cycle
   p_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_o |-> $past((req_i && !kmode_i && !mem_req_o) || priv_fault_i));

   // R9: privilege fault dominates the cause
   p_priv_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      priv_fault_i |=> (trap_cause_o == CAUSE_PRIV));

endmodule

// File: rtl/bl_guard.sv
module bl_guard
   import bl_guard_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit SUB_FORM = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic              cpu_kmode,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              trap_valid,
   output logic [ADDR_W-1:0] trap_addr,
   output logic [1:0]        trap_cause
);

   generate
      if (ADDR_W < 8 || ADDR_W > 62) begin : g_bad_width
         $error("bl_guard: ADDR_W must lie in 8..62");
      end
   endgenerate

   logic [ADDR_W-1:0] win_start;
   logic [ADDR_W-1:0] win_size;
   logic              priv_fault;
   logic              addr_legal;
   trap_cause_e       cause_w;

   bl_window_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_req       (cfg_wr),
      .wr_sel       (cfg_sel),
      .wr_data      (cfg_data),
      .kmode        (cpu_kmode),
      .start_o      (win_start),
      .size_o       (win_size),
      .priv_fault_o (priv_fault)
   );

   bl_range_cmp #(.ADDR_W(ADDR_W), .SUB_FORM(SUB_FORM)) u_cmp (
      .addr_i  (cpu_addr),
      .start_i (win_start),
      .size_i  (win_size),
      .legal_o (addr_legal)
   );

   bl_fault_gate #(.ADDR_W(ADDR_W)) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (cpu_req),
      .addr_i       (cpu_addr),
      .we_i         (cpu_we),
      .kmode_i      (cpu_kmode),
      .legal_i      (addr_legal),
      .priv_fault_i (priv_fault),
      .mem_req_o    (mem_req),
      .mem_addr_o   (mem_addr),
      .mem_we_o     (mem_we),
      .trap_valid_o (trap_valid),
      .trap_addr_o  (trap_addr),
      .trap_cause_o (cause_w)
   );

   assign trap_cause = cause_w;

   // R5: forwarded request carries the core's address and direction
   p_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (cpu_req && mem_addr == cpu_addr && mem_we == cpu_we));

   // R8: a user-mode write always traps on the next cycle
   p_user_wr_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cpu_kmode) |=> trap_valid);

endmodule

// File: tb/bl_guard_bench.sv
module bl_guard_bench;

   localparam int  CLK_P = 10;
   localparam int  AW    = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cpu_req, cpu_we, cpu_kmode, cfg_wr, cfg_sel;
   logic [AW-1:0] cpu_addr, cfg_data;
   logic          mem_req, mem_we, trap_valid;
   logic [AW-1:0] mem_addr, trap_addr;
   logic [1:0]    trap_cause;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   longint ref_start = 0;
   longint ref_size  = 0;
   bit     exp_tv    = 1'b0;
   longint exp_ta    = 0;
   int     exp_tc    = 0;

   always #(CLK_P/2) clk = ~clk;

   bl_guard u_bl_guard (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_kmode(cpu_kmode),
      .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
      .trap_valid(trap_valid), .trap_addr(trap_addr), .trap_cause(trap_cause)
   );

   task automatic chk(input string tag, input longint got, input longint exp);
      n_vec++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic bit ref_legal(input longint a);
      return (ref_size != 0) && (a >= ref_start) && (a <= ref_start + ref_size - 1);
   endfunction

   // one cycle: check trap from previous cycle, drive, check gating, advance model
   task automatic step(input string tag, input bit req, input longint addr, input bit we,
                       input bit k, input bit wr, input bit sel, input longint data);
      bit rf, pf, pass;
      @(negedge clk);
      chk({tag, " R10 trap_valid"}, longint'(trap_valid), longint'(exp_tv));
      chk({tag, " R10 trap_cause"}, longint'(trap_cause), longint'(exp_tc));
      if (exp_tv) chk({tag, " R4 trap_addr"}, longint'(trap_addr), exp_ta);
      cpu_req = req; cpu_addr = AW'(addr); cpu_we = we; cpu_kmode = k;
      cfg_wr = wr; cfg_sel = sel; cfg_data = AW'(data);
      #1;
      rf   = req && !k && !ref_legal(addr);
      pf   = wr && !k;
      pass = req && !rf;
      chk({tag, " R2/R5/R6 mem_req"}, longint'(mem_req), longint'(pass));
      if (pass) begin
         chk({tag, " R5 mem_addr"}, longint'(mem_addr), addr);
         chk({tag, " R12 mem_we"}, longint'(mem_we), longint'(we));
      end
      exp_tv = rf || pf;
      exp_ta = exp_tv ? addr : 0;
      exp_tc = pf ? 2 : (rf ? 1 : 0);
      if (wr && k) begin
         if (sel) ref_size = data; else ref_start = data;
      end
   endtask

   task automatic kset(input longint s, input longint n);
      step("cfg start R7", 0, 0, 0, 1, 1, 0, s);
      step("cfg size R7",  0, 0, 0, 1, 1, 1, n);
   endtask

   task automatic uacc(input string tag, input longint a, input bit we);
      step(tag, 1, a, we, 0, 0, 0, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      cpu_req = 0; cpu_addr = '0; cpu_we = 0; cpu_kmode = 1;
      cfg_wr = 0; cfg_sel = 0; cfg_data = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset trap_valid", longint'(trap_valid), 0);
      chk("R1 reset trap_cause", longint'(trap_cause), 0);
      rst_n = 1'b1;

      // R1/R11: empty window after reset
      uacc("R1 user at 0 after reset", 0, 0);
      uacc("R11 user at 5 after reset", 5, 1);
      step("R6 kernel anywhere", 1, 64'hFFFF_0000, 1, 1, 0, 0, 0);

      // R2 boundaries
      kset(300040, 120900);
      uacc("R2 start", 300040, 0);
      uacc("R2 last", 420939, 1);
      uacc("R2 below", 300039, 0);
      uacc("R2 past end", 420940, 1);
      uacc("R2 middle", 350000, 0);
      uacc("R12 store middle", 350000, 1);
      step("R6 kernel outside", 1, 12, 0, 1, 0, 0, 0);
      step("R6 kernel past end", 1, 420940, 1, 1, 0, 0, 0);

      // R8 user write refused
      step("R8 user write start", 0, 0, 0, 0, 1, 0, 0);
      step("R8 user write size", 0, 0, 0, 0, 1, 1, 1);
      uacc("R8 start kept", 300040, 0);
      uacc("R8 last kept", 420939, 0);
      uacc("R8 below kept", 300039, 1);

      // R9 collision
      step("R9 priv+range", 1, 7, 0, 0, 1, 0, 0);
      step("R9 priv+legal", 1, 400000, 1, 0, 1, 1, 5);
      step("R10 idle", 0, 0, 0, 0, 0, 0, 0);

      // R7 write then immediate use
      step("R7 new start", 0, 0, 0, 1, 1, 0, 1000);
      uacc("R7 new start live", 1000, 0);
      uacc("R7 old start gone", 999, 0);

      // R3 top of space
      kset(64'hFFFF_FFF0, 32);
      uacc("R3 top", 64'hFFFF_FFFF, 0);
      uacc("R3 first", 64'hFFFF_FFF0, 1);
      uacc("R3 zero no wrap", 0, 0);
      uacc("R3 fifteen no wrap", 15, 0);

      // R11 zero size
      kset(500, 0);
      uacc("R11 start with size 0", 500, 0);

      // random traffic near the window edges
      kset(300040, 120900);
      for (int i = 0; i < 400; i++) begin
         longint a;
         int pick = $urandom_range(0, 3);
         if (pick == 0)      a = ref_start + $urandom_range(0, 4) - 2;
         else if (pick == 1) a = ref_start + ref_size + $urandom_range(0, 4) - 2;
         else                a = longint'($urandom);
         if (a < 0) a = 0;
         if (a > 64'hFFFF_FFFF) a = 64'hFFFF_FFFF;
         step("rand R2/R4/R6/R8/R9", $urandom_range(0, 1), a, $urandom_range(0, 1),
              ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0),
              $urandom_range(0, 1), longint'($urandom_range(100000, 600000)));
      end
      step("final", 0, 0, 0, 1, 0, 0, 0);
      step("final", 0, 0, 0, 1, 0, 0, 0);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule